// File: doc/BRIEF.md
# Fractional Output Clock Divider with Triangle Spread

The block turns a fast input clock into a slower output rate. The divide ratio is an integer plus a fraction. It emits `pulse_o`, which is high for one input cycle at the end of each output period. A downstream toggle stage or clock-enable user derives the output clock from that pulse.

In fractional mode, a fraction accumulator makes some periods one cycle longer than the integer part. Over many periods this gives the exact average ratio. An integer-only mode ignores the fraction. A bypass mode divides by one. A triangle modulator can add a slowly rising and falling offset to the ratio, which spreads the output spectrum. The modulation rate is set by the step and the half-length, counted in output periods.

Configuration is written through a simple register port and is picked up only at a period boundary. A shared synchronizing pulse `sync_i` restarts every instance in the same cycle. Instances with the same settings then emit identical pulse trains. No data stream passes through the block, so it has no valid/ready interface. All pins are plain control pins.

Top module: `frac_out_div`

## Requirements
- R1: With mode bit 0 (integer only) set, bit 1 clear and N >= 2, every output period lasts exactly N input cycles. The fraction and the spread settings have no effect on the period length.
- R2: In fractional mode, the 24-bit accumulator is cleared by reset or sync. At each period boundary the effective ratio is added to the accumulator, as the integer part times 2^24 plus the fraction. The whole part of the sum is the length of the next period, so each period is N or N+1 cycles, and the low 24 bits are kept.
- R3: With mode bit 1 (bypass) set, `pulse_o` is high in every cycle: the divider divides by one.
- R4: An integer value N of 0 or 1 acts as bypass in any mode.
- R5: With mode bit 2 (spread) set in fractional mode, an offset in 2^-24 units is added to the ratio. Its value in successive periods starts at 0 and rises by the step for H periods, then falls by the step for H periods, and repeats. The step is bits 15:0 of register 3 and H is bits 27:16 of register 3. H = 0 acts as 1. The offset returns to zero whenever spread is off.
- R6: If `sync_i` is sampled high at edge k, the divider state is cleared and `pulse_o` is low in cycle k. The first pulse then falls in cycle k+L, where L is the first period length, so instances with equal settings are pulse-aligned from then on.
- R7: Register writes take effect only at a period boundary. A write in the middle of a period does not change that period's length.
- R8: During and straight after reset, `pulse_o` is low. The defaults are N = DEF_INT, fraction 0, mode 0, step 0 and H = 1.
- R9: Register address 0 holds N in bits 11:0 and address 1 holds the fraction in bits 23:0. Address 2 holds the mode, with bit 0 integer-only, bit 1 bypass and bit 2 spread. Address 3 holds the step and H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Synchronizing restart shared by all instances |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| pulse_o | output | 1 | One-cycle pulse ending each output period |

## Verification
A write or sync sampled at edge k is visible from cycle k onward. A period boundary in cycle t places the next pulse in cycle t+L. Bypass therefore pulses in every cycle, and a sync sampled at edge k puts the first pulse in cycle k+L.

The bench keeps shadow registers updated at the rising edge. It predicts the next pulse cycle from those registers with wide integer arithmetic on the accumulated ratio. It compares `pulse_o` against that prediction at every falling edge, which is away from the edge that moves the outputs. A second instance, released from reset later, must match the first cycle for cycle once a common sync has been applied.

// File: rtl/ofd_pkg.sv
package ofd_pkg;
  localparam int unsigned ADR_INT    = 0;
  localparam int unsigned ADR_FRAC   = 1;
  localparam int unsigned ADR_MODE   = 2;
  localparam int unsigned ADR_SPREAD = 3;

  // bit 0 int_only, bit 1 bypass, bit 2 spread
  typedef struct packed {
    logic spread;
    logic bypass;
    logic int_only;
  } mode_t;
endpackage

// File: rtl/ofd_cfg_regs.sv
module ofd_cfg_regs
  import ofd_pkg::*;
#(
  parameter int INT_W   = 12,
  parameter int FRAC_W  = 24,
  parameter int STEP_W  = 16,
  parameter int HALF_W  = 12,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 2,
  parameter int DEF_INT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [INT_W-1:0]  n_q,
  output logic [FRAC_W-1:0] f_q,
  output mode_t             mode_q,
  output logic [STEP_W-1:0] step_q,
  output logic [HALF_W-1:0] half_q
);
  localparam int HALF_LO = STEP_W;
  localparam int HALF_HI = STEP_W + HALF_W - 1;

  logic unused_bits;
  assign unused_bits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q    <= INT_W'(DEF_INT);
      f_q    <= '0;
      mode_q <= '0;
      step_q <= '0;
      half_q <= HALF_W'(1);
    end else if (we) begin
      case (addr)
        ADDR_W'(ADR_INT):    n_q    <= wdata[INT_W-1:0];
        ADDR_W'(ADR_FRAC):   f_q    <= wdata[FRAC_W-1:0];
        ADDR_W'(ADR_MODE):   mode_q <= mode_t'(wdata[2:0]);
        ADDR_W'(ADR_SPREAD): begin
          step_q <= wdata[STEP_W-1:0];
          half_q <= wdata[HALF_HI:HALF_LO];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ofd_tri_mod.sv
module ofd_tri_mod #(
  parameter int STEP_W = 16,
  parameter int HALF_W = 12,
  parameter int OFF_W  = STEP_W + HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [STEP_W-1:0] step,
  input  logic [HALF_W-1:0] half,
  output logic [OFF_W-1:0]  off_o
);
  logic              dn;
  logic [HALF_W-1:0] tcnt;
  logic [HALF_W-1:0] half_eff;
  logic              last;

  assign half_eff = (half == '0) ? HALF_W'(1) : half;
  assign last     = (tcnt == half_eff - HALF_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_o <= '0;
      dn    <= 1'b0;
      tcnt  <= '0;
    end else if (clr) begin
      off_o <= '0;
      dn    <= 1'b0;
      tcnt  <= '0;
    end else if (adv) begin
      off_o <= dn ? off_o - OFF_W'(step) : off_o + OFF_W'(step);
      if (last) begin
        tcnt <= '0;
        dn   <= ~dn;
      end else begin
        tcnt <= tcnt + HALF_W'(1);
      end
    end
  end

  AST_TRI_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !adv && $stable(step)) |=> (off_o == '0 && tcnt == '0)) else $error("tri clear"); // R5
endmodule

// File: rtl/ofd_core.sv
module ofd_core
  import ofd_pkg::*;
#(
  parameter int INT_W  = 12,
  parameter int FRAC_W = 24,
  parameter int OFF_W  = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic [INT_W-1:0]  n_i,
  input  logic [FRAC_W-1:0] f_i,
  input  mode_t             mode_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic              pulse_o,
  output logic              tri_clr_o,
  output logic              tri_adv_o
);
  localparam int RAT_W = INT_W + FRAC_W + 1;
  localparam int SUM_W = RAT_W + 1;
  localparam int LEN_W = SUM_W - FRAC_W;

  logic              prime;
  logic [LEN_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic              boundary, byp, spread_act;
  logic [RAT_W-1:0]  ratio;
  logic [SUM_W-1:0]  sum;
  logic [LEN_W-1:0]  len;

  assign boundary   = prime || (cnt == '0);
  assign byp        = mode_i.bypass || (n_i < INT_W'(2));
  assign spread_act = mode_i.spread && !mode_i.int_only && !byp;
  assign ratio      = {1'b0, n_i, f_i} + (spread_act ? RAT_W'(off_i) : RAT_W'(0));
  assign sum        = {1'b0, ratio} + SUM_W'(acc);

  always_comb begin
    if (byp)                  len = LEN_W'(1);
    else if (mode_i.int_only) len = LEN_W'(n_i);
    else                      len = sum[SUM_W-1:FRAC_W];
  end

  assign tri_clr_o = sync_i || (boundary && !spread_act);
  assign tri_adv_o = boundary && spread_act;
  assign pulse_o   = (cnt == '0) && !prime;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prime <= 1'b1;
      cnt   <= '0;
      acc   <= '0;
    end else if (sync_i) begin
      prime <= 1'b1;
      cnt   <= '0;
      acc   <= '0;
    end else if (boundary) begin
      prime <= 1'b0;
      cnt   <= len - LEN_W'(1);
      acc   <= (byp || mode_i.int_only) ? '0 : sum[FRAC_W-1:0];
    end else begin
      cnt   <= cnt - LEN_W'(1);
    end
  end

  AST_GAP_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o && !sync_i && !byp) |=> !pulse_o) else $error("gap"); // R4
  AST_BYPASS_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o && !sync_i && byp) |=> pulse_o) else $error("bypass"); // R3
  AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> !pulse_o) else $error("sync"); // R6
  AST_INT_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && mode_i.int_only && !sync_i) |=> (acc == '0)) else $error("acc"); // R1
endmodule

// File: rtl/frac_out_div.sv
module frac_out_div
  import ofd_pkg::*;
#(
  parameter int INT_W   = 12,
  parameter int FRAC_W  = 24,
  parameter int STEP_W  = 16,
  parameter int HALF_W  = 12,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 2,
  parameter int DEF_INT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              pulse_o
);
  localparam int OFF_W = STEP_W + HALF_W;

  logic [INT_W-1:0]  n_q;
  logic [FRAC_W-1:0] f_q;
  mode_t             mode_q;
  logic [STEP_W-1:0] step_q;
  logic [HALF_W-1:0] half_q;
  logic [OFF_W-1:0]  off;
  logic              tri_clr, tri_adv;

  ofd_cfg_regs #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W), .HALF_W(HALF_W),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEF_INT(DEF_INT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .n_q(n_q), .f_q(f_q), .mode_q(mode_q), .step_q(step_q), .half_q(half_q)
  );

  ofd_tri_mod #(
    .STEP_W(STEP_W), .HALF_W(HALF_W), .OFF_W(OFF_W)
  ) u_tri (
    .clk(clk), .rst_n(rst_n), .clr(tri_clr), .adv(tri_adv),
    .step(step_q), .half(half_q), .off_o(off)
  );

  ofd_core #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .OFF_W(OFF_W)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i),
    .n_i(n_q), .f_i(f_q), .mode_i(mode_q), .off_i(off),
    .pulse_o(pulse_o), .tri_clr_o(tri_clr), .tri_adv_o(tri_adv)
  );
endmodule

// File: tb/sim_frac_out_div.sv
`timescale 1ns/1ps
module sim_frac_out_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rst1_n = 1'b0;
  logic        sync_i = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        pulse0, pulse1;

  always #2 clk = ~clk;

  frac_out_div u0 (.clk(clk), .rst_n(rst_n), .sync_i(sync_i), .cfg_we(cfg_we),
                   .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pulse_o(pulse0));
  frac_out_div u1 (.clk(clk), .rst_n(rst1_n), .sync_i(sync_i), .cfg_we(cfg_we),
                   .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pulse_o(pulse1));

  int    checks = 0;
  int    errors = 0;
  string tag = "R8";
  bit    align_on = 1'b0;
  bit    done = 1'b0;

  // shadow registers (R9 map)
  longint sN, sF, sMode, sStep, sHalf;
  // model state
  longint cyc = 0, next_p = 0, acc = 0, off = 0;
  int     tc = 0;
  bit     dn = 0, prime = 1;
  localparam longint FMASK = 64'hFFFFFF;
  localparam longint OMASK = 64'hFFFFFFF;

  task automatic tri_clear();
    off = 0; dn = 0; tc = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      sN = 8; sF = 0; sMode = 0; sStep = 0; sHalf = 1;
      prime = 1; acc = 0; tri_clear();
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: sN = cfg_wdata[11:0];
          2'd1: sF = cfg_wdata[23:0];
          2'd2: sMode = cfg_wdata[2:0];
          default: begin sStep = cfg_wdata[15:0]; sHalf = cfg_wdata[27:16]; end
        endcase
      end
      if (sync_i) begin prime = 1; acc = 0; tri_clear(); end
    end
  end

  always @(negedge clk) begin
    bit     exp;
    longint len, r, t, h;
    exp = !prime && (cyc == next_p);
    checks++;
    if (pulse0 !== exp) begin
      errors++;
      $display("FAIL %s pulse_o=%0b expected %0b at cycle %0d", tag, pulse0, exp, cyc);
    end
    if (align_on) begin
      checks++;
      if (pulse1 !== pulse0) begin
        errors++;
        $display("FAIL R6 u1 pulse=%0b expected %0b at cycle %0d", pulse1, pulse0, cyc);
      end
    end
    if (prime || cyc == next_p) begin
      if (sMode[1] || sN < 2) begin          // R3 R4
        len = 1; acc = 0; tri_clear();
      end else if (sMode[0]) begin           // R1
        len = sN; acc = 0; tri_clear();
      end else begin                         // R2 R5
        r = (sN << 24) + sF + (sMode[2] ? off : 0);
        t = acc + r;
        len = t >> 24;
        acc = t & FMASK;
        if (sMode[2]) begin
          h = (sHalf == 0) ? 1 : sHalf;
          off = dn ? ((off - sStep) & OMASK) : ((off + sStep) & OMASK);
          if (tc == h - 1) begin tc = 0; dn = ~dn; end
          else tc++;
        end else tri_clear();
      end
      next_p = cyc + len;
      prime = 0;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d); // R9 register port
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_sync();
    @(negedge clk);
    sync_i = 1'b1;
    @(negedge clk);
    sync_i = 1'b0;
  endtask

  initial begin
    tag = "R8";
    idle(4);
    rst_n = 1'b1;
    idle(3);
    rst1_n = 1'b1;
    idle(40);

    tag = "R1";
    wr(2, 32'h1); wr(0, 5); wr(1, 32'h800000);
    wr(3, 32'h0003_4000); idle(60);

    tag = "R2";
    wr(2, 32'h0); wr(0, 3); wr(1, 32'h555555); idle(100);
    wr(1, 32'hC00000); idle(60);

    tag = "R3";
    wr(2, 32'h2); idle(20);

    tag = "R4";
    wr(2, 32'h0); wr(0, 1); idle(15);
    wr(0, 0); idle(15);

    tag = "R5";
    wr(0, 4); wr(1, 32'h100000); wr(3, 32'h0003_C000); wr(2, 32'h4); idle(300);
    wr(2, 32'h0); idle(10); wr(3, 32'h0000_9000); wr(2, 32'h4); idle(120);

    tag = "R7";
    wr(2, 32'h0); wr(1, 0); wr(0, 20);
    pulse_sync(); idle(5);
    wr(0, 3); idle(40);

    tag = "R6";
    pulse_sync();
    align_on = 1'b1;
    idle(50);
    wr(0, 7); wr(1, 32'h333333); idle(60);
    wr(2, 32'h4); wr(3, 32'h0002_8000); idle(80);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule